// File: doc/BRIEF.md
# Single-Way TLB Register File with Page Invalidation

This block holds two single-way translation tables, one for data accesses and one for instruction fetches, as a set of special registers. Each entry has two 32-bit words: a match word, whose bit 0 marks the entry valid, and a translate word. A processor core reaches the words through one register access port. The port carries a 16-bit register number: a group in the upper five bits and an index in the lower eleven.

When a match word is overwritten, any cached translation of the page it used to describe, or of the page it now describes, becomes stale. The block therefore emits page-invalidate requests on a valid/ready output. The old page goes out first, then the new one. It takes no further register access until both have drained.

Indices that would belong to ways 1 to 3 are accepted but have no storage. Reads of those indices, like reads of any other address outside the tables, return a fallback operand supplied with the access. This lets the core keep its destination register unchanged. Translation lookup itself lives elsewhere.

Top module: `tlb_regfile`

## Requirements
- R1: After a synchronous reset every entry is invalid: a match-word read returns 0, no invalidate or read response is pending, and `acc_ready` is high.
- R2: The register number is decoded as group = `acc_addr[15:11]`, index = `acc_addr[10:0]`. Group 1 selects the data table and group 2 the instruction table. Match word of entry i sits at index 512+i and translate word at index 640+i, for i below ENTRIES.
- R3: A match-word write stores the word. A read accepted at clock edge T raises `rd_valid` with the stored word on `rd_data` for the cycle after T, and `rd_valid` is low in every other cycle.
- R4: A translate-word write stores the word, reads back as in R3, and produces no invalidate request.
- R5: On a match-word write whose previous word had bit 0 set, an invalidate is issued for the previous page. The page is the word with its low 13 bits cleared.
- R6: On a match-word write whose new word has bit 0 set, an invalidate is issued for the new page. When both R5 and R6 apply, the old page is presented first and the new page on the following handshake.
- R7: A match-word write where neither the old nor the new word has bit 0 set issues no invalidate.
- R8: In groups 1 and 2, indices 768 to 1535 are accepted. Writes there change no stored word and issue no invalidate. Reads there return `acc_fallback`.
- R9: Any other register number is handled the same way: reads return `acc_fallback` and writes have no effect.
- R10: While an invalidate is presented and `inv_ready` is low, `inv_valid` and `inv_page` hold. `acc_ready` stays low while any invalidate is pending.
- R11: The data and instruction tables are independent: a write to one leaves every word of the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access request |
| acc_ready | output | 1 | Access accepted at this edge when valid is high |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Register number (group, index) |
| acc_wdata | input | 32 | Write data |
| acc_fallback | input | 32 | Value returned by reads of unmapped numbers |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| inv_valid | output | 1 | Page-invalidate request valid |
| inv_ready | input | 1 | Page-invalidate request taken |
| inv_page | output | 32 | Page address to invalidate, low 13 bits zero |

## Verification
The properties assume that `acc_ready` is honoured: an access counts only in a cycle where `acc_valid` and `acc_ready` are both high. They also assume the requester keeps `inv_ready` meaningful under a pending request and that reset is asserted from time zero. The stimulus drives every access on the falling edge and waits for `acc_ready` before presenting one. It holds `inv_ready` high except in the directed back-pressure test, where the held request is observed over several cycles before release. Translate words are only read after being written, since reset leaves their contents undefined.

// File: rtl/tlb_reg_pkg.sv
package tlb_reg_pkg;

  localparam int REGNUM_W    = 16;
  localparam int GROUP_LSB   = 11;
  localparam int INDEX_W     = 11;
  localparam int GROUP_DATA  = 1;
  localparam int GROUP_INSTR = 2;
  localparam int MATCH_BASE  = 512;
  localparam int XLATE_BASE  = 640;
  localparam int UPPER_FIRST = 768;
  localparam int UPPER_LAST  = 1535;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_MATCH = 2'd1,
    ACC_XLATE = 2'd2,
    ACC_UPPER = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/tlb_addr_decode.sv
module tlb_addr_decode
  import tlb_reg_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [REGNUM_W-1:0] addr,
  output acc_kind_e           kind,
  output logic                side,
  output logic [IDX_W-1:0]    idx
);

  localparam logic [INDEX_W-1:0] M_LO = INDEX_W'(MATCH_BASE);
  localparam logic [INDEX_W-1:0] M_HI = INDEX_W'(MATCH_BASE + ENTRIES);
  localparam logic [INDEX_W-1:0] X_LO = INDEX_W'(XLATE_BASE);
  localparam logic [INDEX_W-1:0] X_HI = INDEX_W'(XLATE_BASE + ENTRIES);
  localparam logic [INDEX_W-1:0] U_LO = INDEX_W'(UPPER_FIRST);
  localparam logic [INDEX_W-1:0] U_HI = INDEX_W'(UPPER_LAST);

  logic [REGNUM_W-GROUP_LSB-1:0] grp;
  logic [INDEX_W-1:0]            num;
  logic [INDEX_W-1:0]            off_m;
  logic [INDEX_W-1:0]            off_x;
  logic                          grp_ok;

  assign grp    = addr[REGNUM_W-1:GROUP_LSB];
  assign num    = addr[INDEX_W-1:0];
  assign off_m  = num - M_LO;
  assign off_x  = num - X_LO;
  assign grp_ok = (grp == (REGNUM_W-GROUP_LSB)'(GROUP_DATA)) ||
                  (grp == (REGNUM_W-GROUP_LSB)'(GROUP_INSTR));
  assign side   = (grp == (REGNUM_W-GROUP_LSB)'(GROUP_INSTR));

  always_comb begin
    kind = ACC_NONE;
    idx  = off_m[IDX_W-1:0];
    if (grp_ok) begin
      if (num >= M_LO && num < M_HI) begin
        kind = ACC_MATCH;
      end else if (num >= X_LO && num < X_HI) begin
        kind = ACC_XLATE;
        idx  = off_x[IDX_W-1:0];
      end else if (num >= U_LO && num <= U_HI) begin
        kind = ACC_UPPER;
      end
    end
  end

endmodule

// File: rtl/tlb_word_bank.sv
module tlb_word_bank #(
  parameter int DEPTH    = 128,
  parameter int WIDTH    = 32,
  parameter int AW       = $clog2(DEPTH),
  parameter bit REG_READ = 1'b1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  generate
    if (REG_READ) begin : g_sync
      logic [WIDTH-1:0] rdata_q;
      always_ff @(posedge clk) begin
        rdata_q <= mem[raddr];
      end
      assign rdata = rdata_q;
    end else begin : g_async
      assign rdata = mem[raddr];
    end
  endgenerate

endmodule

// File: rtl/tlb_inv_queue.sv
module tlb_inv_queue #(
  parameter int WIDTH     = 32,
  parameter int PAGE_BITS = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] old_word,
  input  logic [WIDTH-1:0] new_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_page,
  output logic             busy
);

  localparam logic [WIDTH-1:0] PAGE_MASK = ~((WIDTH'(1) << PAGE_BITS) - WIDTH'(1));

  logic             head_v, tail_v;
  logic [WIDTH-1:0] head_p, tail_p;
  logic [WIDTH-1:0] old_pg, new_pg;

  assign old_pg = old_word & PAGE_MASK;
  assign new_pg = new_word & PAGE_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_v <= 1'b0;
      tail_v <= 1'b0;
      head_p <= '0;
      tail_p <= '0;
    end else if (load) begin
      // old page always leaves first
      if (old_word[0]) begin
        head_v <= 1'b1;
        head_p <= old_pg;
        tail_v <= new_word[0];
        tail_p <= new_pg;
      end else begin
        head_v <= new_word[0];
        head_p <= new_pg;
        tail_v <= 1'b0;
      end
    end else if (head_v && out_ready) begin
      head_v <= tail_v;
      head_p <= tail_p;
      tail_v <= 1'b0;
    end
  end

  assign out_valid = head_v;
  assign out_page  = head_p;
  assign busy      = head_v | tail_v;

endmodule

// File: rtl/tlb_regfile.sv
module tlb_regfile
  import tlb_reg_pkg::*;
#(
  parameter int ENTRIES   = 128,
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_valid,
  output logic                acc_ready,
  input  logic                acc_write,
  input  logic [REGNUM_W-1:0] acc_addr,
  input  logic [DATA_W-1:0]   acc_wdata,
  input  logic [DATA_W-1:0]   acc_fallback,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                inv_valid,
  input  logic                inv_ready,
  output logic [DATA_W-1:0]   inv_page
);

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int SIDES  = 2;

  acc_kind_e        kind;
  logic             side;
  logic [IDX_W-1:0] idx;
  logic             fire;
  logic             busy;
  logic             match_wr;

  logic [DATA_W-1:0] old_word [SIDES];
  logic [DATA_W-1:0] xl_rd    [SIDES];

  tlb_addr_decode #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) dec_i (
    .addr (acc_addr),
    .kind (kind),
    .side (side),
    .idx  (idx)
  );

  assign acc_ready = ~busy;
  assign fire      = acc_valid & acc_ready;
  assign match_wr  = fire & acc_write & (kind == ACC_MATCH);

  generate
    for (genvar g = 0; g < SIDES; g++) begin : g_side
      logic              m_hit, x_hit;
      logic [ENTRIES-1:0] live_q;
      logic [DATA_W-1:0] m_raw;

      assign m_hit = (kind == ACC_MATCH) && (side == 1'(g));
      assign x_hit = (kind == ACC_XLATE) && (side == 1'(g));

      // per-entry written-since-reset flags give a one-cycle clear
      always_ff @(posedge clk) begin
        if (rst) begin
          live_q <= '0;
        end else if (fire && acc_write && m_hit) begin
          live_q[idx] <= 1'b1;
        end
      end

      tlb_word_bank #(
        .DEPTH    (ENTRIES),
        .WIDTH    (DATA_W),
        .AW       (IDX_W),
        .REG_READ (1'b0)
      ) match_bank_i (
        .clk   (clk),
        .we    (fire & acc_write & m_hit),
        .waddr (idx),
        .wdata (acc_wdata),
        .raddr (idx),
        .rdata (m_raw)
      );

      assign old_word[g] = live_q[idx] ? m_raw : '0;

      tlb_word_bank #(
        .DEPTH    (ENTRIES),
        .WIDTH    (DATA_W),
        .AW       (IDX_W),
        .REG_READ (1'b1)
      ) xlate_bank_i (
        .clk   (clk),
        .we    (fire & acc_write & x_hit),
        .waddr (idx),
        .wdata (acc_wdata),
        .raddr (idx),
        .rdata (xl_rd[g])
      );
    end
  endgenerate

  tlb_inv_queue #(
    .WIDTH     (DATA_W),
    .PAGE_BITS (PAGE_BITS)
  ) invq_i (
    .clk       (clk),
    .rst       (rst),
    .load      (match_wr),
    .old_word  (old_word[side]),
    .new_word  (acc_wdata),
    .out_valid (inv_valid),
    .out_ready (inv_ready),
    .out_page  (inv_page),
    .busy      (busy)
  );

  // read response stage
  logic              rd_valid_q;
  acc_kind_e         kind_q;
  logic              side_q;
  logic [DATA_W-1:0] match_q;
  logic [DATA_W-1:0] fb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      kind_q     <= ACC_NONE;
      side_q     <= 1'b0;
      match_q    <= '0;
      fb_q       <= '0;
    end else begin
      rd_valid_q <= fire & ~acc_write;
      if (fire && !acc_write) begin
        kind_q  <= kind;
        side_q  <= side;
        match_q <= old_word[side];
        fb_q    <= acc_fallback;
      end
    end
  end

  assign rd_valid = rd_valid_q;

  always_comb begin
    case (kind_q)
      ACC_MATCH: rd_data = match_q;
      ACC_XLATE: rd_data = xl_rd[side_q];
      default:   rd_data = fb_q;
    endcase
  end

endmodule

// File: rtl/tlb_regfile_chk.sv
module tlb_regfile_chk
  import tlb_reg_pkg::*;
#(
  parameter int ENTRIES   = 128,
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 13
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_valid,
  input logic                acc_ready,
  input logic                acc_write,
  input logic [REGNUM_W-1:0] acc_addr,
  input logic                rd_valid,
  input logic                inv_valid,
  input logic                inv_ready,
  input logic [DATA_W-1:0]   inv_page
);

  logic [REGNUM_W-GROUP_LSB-1:0] grp;
  logic [INDEX_W-1:0]            num;
  logic                          tbl_grp, wr_fire, rd_fire, upper_num, xlate_num;

  assign grp       = acc_addr[REGNUM_W-1:GROUP_LSB];
  assign num       = acc_addr[INDEX_W-1:0];
  assign tbl_grp   = (grp == 5'd1) || (grp == 5'd2);
  assign wr_fire   = acc_valid && acc_ready && acc_write;
  assign rd_fire   = acc_valid && acc_ready && !acc_write;
  assign upper_num = (int'(num) >= UPPER_FIRST) && (int'(num) <= UPPER_LAST);
  assign xlate_num = (int'(num) >= XLATE_BASE) && (int'(num) < XLATE_BASE + ENTRIES);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!inv_valid && !rd_valid && acc_ready));

  p_rd_follows_r3: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> rd_valid);

  p_rd_only_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> !rd_valid);

  p_xlate_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && tbl_grp && xlate_num) |=> !inv_valid);

  p_page_align_r5: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (inv_page[PAGE_BITS-1:0] == '0));

  p_upper_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && tbl_grp && upper_num) |=> !inv_valid);

  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !acc_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_page)));

endmodule

bind tlb_regfile tlb_regfile_chk #(
  .ENTRIES   (ENTRIES),
  .DATA_W    (DATA_W),
  .PAGE_BITS (PAGE_BITS)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .acc_write (acc_write),
  .acc_addr  (acc_addr),
  .rd_valid  (rd_valid),
  .inv_valid (inv_valid),
  .inv_ready (inv_ready),
  .inv_page  (inv_page)
);

// File: tb/tlb_regfile_tb_top.sv
`timescale 1ns/1ps
module tlb_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic        acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_fallback = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        inv_valid;
  logic        inv_ready = 1'b1;
  logic [31:0] inv_page;

  always #4 clk = ~clk;

  tlb_regfile dut_i (
    .clk (clk), .rst (rst),
    .acc_valid (acc_valid), .acc_ready (acc_ready), .acc_write (acc_write),
    .acc_addr (acc_addr), .acc_wdata (acc_wdata), .acc_fallback (acc_fallback),
    .rd_valid (rd_valid), .rd_data (rd_data),
    .inv_valid (inv_valid), .inv_ready (inv_ready), .inv_page (inv_page)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [15:0] addr;
    logic [31:0] wd;
    logic [31:0] fb;
    logic [31:0] exp;
    logic [1:0]  ninv;
    logic [31:0] p0;
    logic [31:0] p1;
  } vec_t;

  localparam int NV = 20;
  // addresses: data match 0x0A00+i, data xlate 0x0A80+i,
  //            instr match 0x1200+i, instr xlate 0x1280+i
  localparam vec_t VECS [NV] = '{
    '{4'd1,  1'b0, 16'h0A00, 32'h0,         32'hDEAD0001, 32'h0,         2'd0, 32'h0,         32'h0},         // R1 empty after reset
    '{4'd6,  1'b1, 16'h0A00, 32'h0001_2001, 32'h0,        32'h0,         2'd1, 32'h0001_2000, 32'h0},         // R6 new only
    '{4'd3,  1'b0, 16'h0A00, 32'h0,         32'h1111_1111, 32'h0001_2001, 2'd0, 32'h0,        32'h0},         // R3
    '{4'd6,  1'b1, 16'h0A00, 32'h0003_4567, 32'h0,        32'h0,         2'd2, 32'h0001_2000, 32'h0003_4000}, // R5 R6 old first
    '{4'd5,  1'b1, 16'h0A00, 32'h0005_6FFE, 32'h0,        32'h0,         2'd1, 32'h0003_4000, 32'h0},         // R5 old only
    '{4'd7,  1'b1, 16'h0A00, 32'h0007_8000, 32'h0,        32'h0,         2'd0, 32'h0,         32'h0},         // R7 neither
    '{4'd3,  1'b0, 16'h0A00, 32'h0,         32'h2222_2222, 32'h0007_8000, 2'd0, 32'h0,        32'h0},         // R3
    '{4'd4,  1'b1, 16'h0A80, 32'hCAFE_0123, 32'h0,        32'h0,         2'd0, 32'h0,         32'h0},         // R4 no inval
    '{4'd4,  1'b0, 16'h0A80, 32'h0,         32'h3333_3333, 32'hCAFE_0123, 2'd0, 32'h0,        32'h0},         // R4
    '{4'd2,  1'b1, 16'h127F, 32'hFFFF_E001, 32'h0,        32'h0,         2'd1, 32'hFFFF_E000, 32'h0},         // R2 last instr entry
    '{4'd2,  1'b0, 16'h127F, 32'h0,         32'h4444_4444, 32'hFFFF_E001, 2'd0, 32'h0,        32'h0},         // R2
    '{4'd11, 1'b0, 16'h0A7F, 32'h0,         32'h5555_5555, 32'h0,         2'd0, 32'h0,        32'h0},         // R11 data side untouched
    '{4'd8,  1'b1, 16'h0B00, 32'h1111_2001, 32'h0,        32'h0,         2'd0, 32'h0,         32'h0},         // R8 upper write dropped
    '{4'd8,  1'b0, 16'h0B00, 32'h0,         32'h5A5A_5A5A, 32'h5A5A_5A5A, 2'd0, 32'h0,        32'h0},         // R8
    '{4'd8,  1'b0, 16'h0DFF, 32'h0,         32'h0123_4567, 32'h0123_4567, 2'd0, 32'h0,        32'h0},         // R8 last upper
    '{4'd9,  1'b0, 16'h0200, 32'h0,         32'h89AB_CDEF, 32'h89AB_CDEF, 2'd0, 32'h0,        32'h0},         // R9 group 0
    '{4'd9,  1'b1, 16'h1A00, 32'h0000_2001, 32'h0,        32'h0,         2'd0, 32'h0,         32'h0},         // R9 group 3
    '{4'd9,  1'b0, 16'h1600, 32'h0,         32'h7777_0000, 32'h7777_0000, 2'd0, 32'h0,        32'h0},         // R9 index 1536
    '{4'd11, 1'b1, 16'h1285, 32'h1357_2468, 32'h0,        32'h0,         2'd0, 32'h0,         32'h0},         // R11
    '{4'd11, 1'b0, 16'h0A00, 32'h0,         32'h6666_6666, 32'h0007_8000, 2'd0, 32'h0,        32'h0}          // R11 data m0 intact
  };

  int          nvec = 0;
  int          nmis = 0;
  bit          done = 1'b0;
  logic        got_rdv;
  logic [31:0] got_rd;
  int          got_n;
  logic [31:0] got_pg [4];

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic wr, input logic [15:0] a,
                        input logic [31:0] wd, input logic [31:0] fb);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a;
    acc_wdata = wd; acc_fallback = fb;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    got_rdv = rd_valid;
    got_rd  = rd_data;
    got_n   = 0;
    for (int k = 0; k < 4; k++) begin
      if (inv_valid) begin
        got_pg[got_n] = inv_page;
        got_n++;
        @(posedge clk);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nmis++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    check(1, {31'd0, acc_ready}, 32'd1, "acc_ready after reset");
    check(1, {31'd0, inv_valid}, 32'd0, "inv_valid after reset");
    check(1, {31'd0, rd_valid},  32'd0, "rd_valid after reset");

    for (int v = 0; v < NV; v++) begin
      run_op(VECS[v].wr, VECS[v].addr, VECS[v].wd, VECS[v].fb);
      check(int'(VECS[v].req), {31'd0, got_rdv}, {31'd0, ~VECS[v].wr}, "rd_valid");
      if (!VECS[v].wr) check(int'(VECS[v].req), got_rd, VECS[v].exp, "rd_data");
      check(int'(VECS[v].req), got_n, int'(VECS[v].ninv), "invalidate count");
      if (got_n >= 1 && VECS[v].ninv >= 1) check(int'(VECS[v].req), got_pg[0], VECS[v].p0, "first page");
      if (got_n >= 2 && VECS[v].ninv >= 2) check(int'(VECS[v].req), got_pg[1], VECS[v].p1, "second page");
    end

    // R10 back-pressure: two pending pages, ready held low
    run_op(1'b1, 16'h0A01, 32'h0000_2001, 32'h0);
    @(negedge clk);
    inv_ready = 1'b0;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 16'h0A01; acc_wdata = 32'h0000_4001;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      check(10, {31'd0, inv_valid}, 32'd1, "inv_valid held");
      check(10, inv_page, 32'h0000_2000, "inv_page held");
      check(10, {31'd0, acc_ready}, 32'd0, "acc_ready low while pending");
      @(negedge clk);
    end
    inv_ready = 1'b1;
    @(negedge clk);
    check(10, inv_page, 32'h0000_4000, "second page after release");
    @(negedge clk);
    check(10, {31'd0, inv_valid}, 32'd0, "drained");

    // R1 reset clears match words
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    run_op(1'b0, 16'h0A01, 32'h0, 32'hABCD_0000);
    check(1, got_rd, 32'h0, "match word cleared by reset");
    run_op(1'b1, 16'h0A00, 32'h0009_A001, 32'h0);
    check(1, got_n, 1, "only new page after reset");
    check(1, got_pg[0], 32'h0009_A000, "page after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

endmodule